// File: doc/BRIEF.md
# Serial Channel Command and Break Controller

This block is the command and transmit-side controller of one asynchronous serial channel. Software writes an 8-bit command byte. The byte carries two things: four enable and disable bits, one pair for the receiver and one pair for the transmitter, and a 3-bit field that selects one miscellaneous action. From these writes the block keeps the transmitter and receiver enable state. It issues one-cycle strobes to the neighbouring receiver, status and mode-register logic. It also sequences a break condition on the serial output.

On the transmit side, the block holds one character in a holding register and a frame in a shift register. It shifts each frame onto the serial line, one bit for every `OVS` pulses of a 16x tick input. A start-break request is timed against this pipeline. It waits for every queued character, and it is ignored when the transmitter is disabled. A stop-break request returns the line high and guarantees one full bit time of marking before the next character. Disabling the transmitter drops the ready and empty flags at once, but the characters already accepted still drain.

Top module: `uart_cmd_ctrl`

## Requirements
- R1: The command byte is decoded as follows. Bit 0 enables the receiver and bit 1 disables it. Bit 2 enables the transmitter and bit 3 disables it. Bits 6:4 hold the miscellaneous command. Bit 7 is reserved and has no effect, so a write of 0x80 produces no strobe. After reset `txd` is 1, and `tx_rdy`, `tx_emt`, `rx_en` and all strobes are 0.
- R2: Miscellaneous command 1 pulses `mr_ptr_rst` for exactly one cycle, in the cycle after the write.
- R3: Miscellaneous command 2 pulses `rx_reset` and leaves `rx_en` at 0, even when the same write also sets the receiver-enable bit.
- R4: Miscellaneous command 3 resets the transmitter. The transmitter is disabled, the held character and the frame in progress are dropped, any break is cancelled, and `txd` is 1 from the next cycle on.
- R5: Miscellaneous command 4 pulses `err_clr` and command 5 pulses `brk_int_clr`. No other write pulses either strobe.
- R6: The receiver-enable bit sets `rx_en` and pulses `rx_search`. The receiver-disable bit clears `rx_en` in the next cycle without pulsing `err_clr`. When both bits are set, disable wins and no search pulse is issued.
- R7: The transmitter-enable bit raises `tx_rdy` when the holding register is empty. `tx_emt` is high when the transmitter is enabled and nothing is held, shifting or in a break. When both transmitter bits are set, disable wins.
- R8: The transmitter-disable bit clears `tx_rdy` and `tx_emt` in the next cycle. A character already held or shifting is still sent completely. Character writes are ignored while the transmitter is disabled.
- R9: Each frame is one low start bit, eight data bits sent LSB first, and one high stop bit, each bit `OVS` ticks long. A character loaded while another one shifts follows it.
- R10: A start-break command (misc 6) with the transmitter idle drives `txd` low within two bit times. The line stays low until a stop-break command.
- R11: A start-break command issued with a character held or shifting begins only after that character, and any character loaded after it, has been sent.
- R12: A start-break command is ignored unless the transmitter is enabled once the same write's enable and disable bits are applied.
- R13: A stop-break command (misc 7) returns `txd` high within two bit times. The line then stays high for at least one bit time before the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling tick, `OVS` per bit |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_data | input | 8 | Command byte |
| thr_we | input | 1 | Character write strobe |
| thr_data | input | DATA_W | Character to transmit |
| txd | output | 1 | Serial output, high when idle |
| tx_rdy | output | 1 | Holding register can accept a character |
| tx_emt | output | 1 | Transmitter enabled and fully empty |
| rx_en | output | 1 | Receiver enable level |
| rx_search | output | 1 | Pulse: receiver restarts its start-bit search |
| rx_reset | output | 1 | Pulse: receiver hard reset and FIFO flush |
| mr_ptr_rst | output | 1 | Pulse: mode-register pointer back to first |
| err_clr | output | 1 | Pulse: clear receive error status bits |
| brk_int_clr | output | 1 | Pulse: clear break-change interrupt flag |

## Verification
The bench builds the block with `OVS` = 4 and `DATA_W` = 8, and it pulses `tick16` on every other clock, so one bit lasts eight cycles. With these values the two-bit windows of break start and stop, and the one-bit marking gap, span only a few tens of cycles. Whole frames, back-to-back characters and drain-after-disable sequences therefore fit in short directed scenarios. The bench rebuilds every frame from the line by sampling mid-bit, and it measures the break windows with cycle counters.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;

    typedef enum logic [2:0] {
        MISC_NONE   = 3'd0,
        MISC_MRPTR  = 3'd1,
        MISC_RXRST  = 3'd2,
        MISC_TXRST  = 3'd3,
        MISC_ERRCLR = 3'd4,
        MISC_BRKCLR = 3'd5,
        MISC_BRKON  = 3'd6,
        MISC_BRKOFF = 3'd7
    } misc_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SHIFT = 2'd1,
        TX_BREAK = 2'd2,
        TX_GAP   = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic rx_on;
        logic rx_off;
        logic tx_on;
        logic tx_off;
        logic mr_rst;
        logic rx_rst;
        logic tx_rst;
        logic err_clr;
        logic brk_clr;
        logic brk_on;
        logic brk_off;
    } cmd_req_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
    import uart_cmd_pkg::*;
(
    input  logic       cmd_we,
    input  logic [7:0] cmd_data,
    output cmd_req_t   req
);
    localparam int MISC_N = 8;

    logic [MISC_N-1:0] misc_hot;
    logic              unused_rsvd;

    assign unused_rsvd = cmd_data[7];

    for (genvar i = 0; i < MISC_N; i++) begin : g_misc
        assign misc_hot[i] = cmd_we && (cmd_data[6:4] == 3'(i));
    end

    always_comb begin
        req         = '0;
        req.rx_on   = cmd_we && cmd_data[0];
        req.rx_off  = cmd_we && cmd_data[1];
        req.tx_on   = cmd_we && cmd_data[2];
        req.tx_off  = cmd_we && cmd_data[3];
        req.mr_rst  = misc_hot[MISC_MRPTR];
        req.rx_rst  = misc_hot[MISC_RXRST];
        req.tx_rst  = misc_hot[MISC_TXRST];
        req.err_clr = misc_hot[MISC_ERRCLR];
        req.brk_clr = misc_hot[MISC_BRKCLR];
        req.brk_on  = misc_hot[MISC_BRKON];
        req.brk_off = misc_hot[MISC_BRKOFF];
    end
endmodule

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    output logic bit_end
);
    localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;

    logic [CNT_W-1:0] sub_d, sub_q;

    assign bit_end = tick16 && (sub_q == CNT_W'(OVS - 1));

    always_comb begin
        sub_d = sub_q;
        if (tick16) begin
            sub_d = bit_end ? '0 : sub_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sub_q <= '0;
        else        sub_q <= sub_d;
    end
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_cmd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_end,
    input  cmd_req_t          req,
    input  logic              thr_we,
    input  logic [DATA_W-1:0] thr_data,
    output logic              txd,
    output logic              tx_rdy,
    output logic              tx_emt
);
    localparam int FRAME  = DATA_W + 2;
    localparam int BCNT_W = $clog2(FRAME + 1);

    typedef struct packed {
        tx_state_e         st;
        logic              en;
        logic              hold_v;
        logic [DATA_W-1:0] hold;
        logic [FRAME-1:0]  sh;
        logic [BCNT_W-1:0] left;
        logic              brk_pend;
        logic              brk_stop;
    } tx_reg_t;

    tx_reg_t r_d, r_q, rst_v;
    logic    go_next;

    always_comb begin
        rst_v          = '0;
        rst_v.st       = TX_IDLE;
        rst_v.sh       = '1;
    end

    always_comb begin
        r_d     = r_q;
        go_next = 1'b0;

        // shift pipeline, advanced on bit boundaries only
        unique case (r_q.st)
            TX_IDLE: begin
                go_next = bit_end;
            end
            TX_SHIFT: begin
                if (bit_end) begin
                    r_d.sh   = {1'b1, r_q.sh[FRAME-1:1]};
                    r_d.left = r_q.left - 1'b1;
                    go_next  = (r_q.left == BCNT_W'(1));
                end
            end
            TX_BREAK: begin
                if (bit_end && r_q.brk_stop) begin
                    r_d.st       = TX_GAP;
                    r_d.brk_stop = 1'b0;
                end
            end
            TX_GAP: begin
                go_next = bit_end;
            end
            default: r_d.st = TX_IDLE;
        endcase

        // next job: queued character first, then a pending break
        if (go_next) begin
            if (r_q.hold_v) begin
                r_d.sh     = {1'b1, r_q.hold, 1'b0};
                r_d.left   = BCNT_W'(FRAME);
                r_d.hold_v = 1'b0;
                r_d.st     = TX_SHIFT;
            end else if (r_q.brk_pend) begin
                r_d.brk_pend = 1'b0;
                r_d.brk_stop = 1'b0;
                r_d.st       = TX_BREAK;
            end else begin
                r_d.st = TX_IDLE;
            end
        end

        // character load
        if (thr_we && r_q.en && !r_q.hold_v) begin
            r_d.hold_v = 1'b1;
            r_d.hold   = thr_data;
        end

        // enable bits: disable dominates
        if (req.tx_off)     r_d.en = 1'b0;
        else if (req.tx_on) r_d.en = 1'b1;

        // break commands, judged against the updated state
        if (req.brk_off) begin
            r_d.brk_pend = 1'b0;
            if (r_d.st == TX_BREAK) r_d.brk_stop = 1'b1;
        end
        if (req.brk_on && r_d.en && (r_d.st != TX_BREAK)) begin
            r_d.brk_pend = 1'b1;
        end

        // transmitter reset overrides everything in the same write
        if (req.tx_rst) begin
            r_d = rst_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= rst_v;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (r_q.st)
            TX_SHIFT: txd = r_q.sh[0];
            TX_BREAK: txd = 1'b0;
            default:  txd = 1'b1;
        endcase
    end

    assign tx_rdy = r_q.en && !r_q.hold_v;
    assign tx_emt = r_q.en && !r_q.hold_v && (r_q.st == TX_IDLE);
endmodule

// File: rtl/uart_cmd_ctrl.sv
module uart_cmd_ctrl
    import uart_cmd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_data,
    input  logic              thr_we,
    input  logic [DATA_W-1:0] thr_data,
    output logic              txd,
    output logic              tx_rdy,
    output logic              tx_emt,
    output logic              rx_en,
    output logic              rx_search,
    output logic              rx_reset,
    output logic              mr_ptr_rst,
    output logic              err_clr,
    output logic              brk_int_clr
);
    typedef struct packed {
        logic rx_en;
        logic search;
        logic rx_rst;
        logic mr_rst;
        logic err;
        logic brk;
    } ctl_reg_t;

    cmd_req_t req;
    logic     bit_end;
    ctl_reg_t c_d, c_q;

    uart_cmd_decode u_dec (
        .cmd_we   (cmd_we),
        .cmd_data (cmd_data),
        .req      (req)
    );

    uart_bit_timer #(.OVS(OVS)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick16  (tick16),
        .bit_end (bit_end)
    );

    uart_tx_engine #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_end  (bit_end),
        .req      (req),
        .thr_we   (thr_we),
        .thr_data (thr_data),
        .txd      (txd),
        .tx_rdy   (tx_rdy),
        .tx_emt   (tx_emt)
    );

    always_comb begin
        c_d        = c_q;
        c_d.mr_rst = req.mr_rst;
        c_d.rx_rst = req.rx_rst;
        c_d.err    = req.err_clr;
        c_d.brk    = req.brk_clr;
        c_d.search = req.rx_on && !req.rx_off && !req.rx_rst;
        if (req.rx_rst || req.rx_off) c_d.rx_en = 1'b0;
        else if (req.rx_on)           c_d.rx_en = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rx_en       = c_q.rx_en;
    assign rx_search   = c_q.search;
    assign rx_reset    = c_q.rx_rst;
    assign mr_ptr_rst  = c_q.mr_rst;
    assign err_clr     = c_q.err;
    assign brk_int_clr = c_q.brk;
endmodule

// File: rtl/uart_cmd_ctrl_chk.sv
module uart_cmd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_we,
    input logic [7:0] cmd_data,
    input logic       txd,
    input logic       tx_rdy,
    input logic       tx_emt,
    input logic       rx_en,
    input logic       rx_search,
    input logic       rx_reset,
    input logic       mr_ptr_rst,
    input logic       err_clr,
    input logic       brk_int_clr
);
    p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mr_ptr_rst, rx_reset, err_clr, brk_int_clr}));

    p_mr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data[6:4] == 3'd1) |=> mr_ptr_rst);

    p_rx_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data[6:4] == 3'd2) |=> (rx_reset && !rx_en));

    p_tx_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data[6:4] == 3'd3) |=> (txd && !tx_rdy && !tx_emt));

    p_err_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_we && cmd_data[6:4] == 3'd4) |=> !err_clr);

    p_rx_off_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data[1]) |=> (!rx_en && !rx_search));

    p_emt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_emt |-> (tx_rdy && txd));

    p_tx_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_data[3]) |=> (!tx_rdy && !tx_emt));
endmodule

bind uart_cmd_ctrl uart_cmd_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (cmd_we),
    .cmd_data    (cmd_data),
    .txd         (txd),
    .tx_rdy      (tx_rdy),
    .tx_emt      (tx_emt),
    .rx_en       (rx_en),
    .rx_search   (rx_search),
    .rx_reset    (rx_reset),
    .mr_ptr_rst  (mr_ptr_rst),
    .err_clr     (err_clr),
    .brk_int_clr (brk_int_clr)
);

// File: tb/sim_uart_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_uart_cmd_ctrl;
    localparam int DATA_W = 8;
    localparam int OVS    = 4;
    localparam int BITC   = OVS * 2;   // tick every other clock
    localparam int LIM    = 40 * BITC;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick16 = 1'b0;
    logic             cmd_we = 1'b0;
    logic [7:0]       cmd_data = '0;
    logic             thr_we = 1'b0;
    logic [DATA_W-1:0] thr_data = '0;
    logic txd, tx_rdy, tx_emt, rx_en, rx_search, rx_reset;
    logic mr_ptr_rst, err_clr, brk_int_clr;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n) tick16 <= ~tick16;
    end

    uart_cmd_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .cmd_we(cmd_we), .cmd_data(cmd_data),
        .thr_we(thr_we), .thr_data(thr_data),
        .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt),
        .rx_en(rx_en), .rx_search(rx_search), .rx_reset(rx_reset),
        .mr_ptr_rst(mr_ptr_rst), .err_clr(err_clr), .brk_int_clr(brk_int_clr)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_le(input string req, input int act, input int lim);
        checks++;
        if (act > lim) begin
            errs++;
            $display("FAIL %s actual=%0d expected<=%0d", req, act, lim);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int lim);
        checks++;
        if (act < lim) begin
            errs++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
        end
    endtask

    task automatic cmd(input logic [7:0] v);
        @(negedge clk);
        cmd_we = 1'b1; cmd_data = v;
        @(negedge clk);
        cmd_we = 1'b0; cmd_data = '0;
    endtask

    task automatic thr(input logic [7:0] v);
        @(negedge clk);
        thr_we = 1'b1; thr_data = v;
        @(negedge clk);
        thr_we = 1'b0; thr_data = '0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_low(output int n);
        n = 0;
        while (txd !== 1'b0 && n < LIM) begin @(negedge clk); n++; end
    endtask

    task automatic wait_high(output int n);
        n = 0;
        while (txd !== 1'b1 && n < LIM) begin @(negedge clk); n++; end
    endtask

    task automatic count_lows(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
    endtask

    // called right after the start bit edge was seen
    task automatic rx_after_start(output logic [7:0] v, output int st, output int sp);
        wait_cycles(BITC / 2);
        st = int'(txd);
        for (int b = 0; b < 8; b++) begin
            wait_cycles(BITC);
            v[b] = txd;
        end
        wait_cycles(BITC);
        sp = int'(txd);
    endtask

    task automatic rx_char(input string req, input logic [7:0] exp);
        int n, st, sp;
        logic [7:0] v;
        wait_low(n);
        chk_le({req, " start bit seen"}, n, LIM - 1);
        rx_after_start(v, st, sp);
        chk({req, " start bit"}, st, 0);
        chk({req, " data"}, int'(v), int'(exp));
        chk({req, " stop bit"}, sp, 1);
    endtask

    task automatic t_reset_state;
        chk("R1 reset txd", int'(txd), 1);
        chk("R1 reset tx_rdy", int'(tx_rdy), 0);
        chk("R1 reset tx_emt", int'(tx_emt), 0);
        chk("R1 reset rx_en", int'(rx_en), 0);
        chk("R1 reset strobes", int'({rx_search, rx_reset, mr_ptr_rst, err_clr, brk_int_clr}), 0);
    endtask

    task automatic t_misc_strobes;
        cmd(8'h80);
        chk("R1 reserved bit no strobe", int'({rx_search, rx_reset, mr_ptr_rst, err_clr, brk_int_clr}), 0);
        chk("R1 reserved bit no enable", int'({rx_en, tx_rdy}), 0);
        cmd(8'h10);
        chk("R2 mr pointer pulse", int'(mr_ptr_rst), 1);
        @(negedge clk);
        chk("R2 mr pointer one cycle", int'(mr_ptr_rst), 0);
        cmd(8'h40);
        chk("R5 error clear pulse", int'(err_clr), 1);
        chk("R5 no break clear on 4", int'(brk_int_clr), 0);
        cmd(8'h50);
        chk("R5 break clear pulse", int'(brk_int_clr), 1);
        chk("R5 no error clear on 5", int'(err_clr), 0);
    endtask

    task automatic t_rx_ctrl;
        cmd(8'h01);
        chk("R6 rx enable level", int'(rx_en), 1);
        chk("R6 rx search pulse", int'(rx_search), 1);
        @(negedge clk);
        chk("R6 rx search one cycle", int'(rx_search), 0);
        cmd(8'h02);
        chk("R6 rx disable level", int'(rx_en), 0);
        chk("R6 rx disable no error clear", int'(err_clr), 0);
        cmd(8'h03);
        chk("R6 both rx bits disable wins", int'({rx_en, rx_search}), 0);
        cmd(8'h01);
        cmd(8'h21);
        chk("R3 rx reset pulse", int'(rx_reset), 1);
        chk("R3 rx reset keeps disabled", int'(rx_en), 0);
    endtask

    task automatic t_frames;
        int n;
        cmd(8'h0C);
        chk("R7 both tx bits disable wins", int'(tx_rdy), 0);
        cmd(8'h04);
        chk("R7 tx enable ready", int'(tx_rdy), 1);
        chk("R7 tx enable empty", int'(tx_emt), 1);
        thr(8'hA5);
        chk("R7 not empty when loaded", int'(tx_emt), 0);
        rx_char("R9 frame A5", 8'hA5);
        thr(8'h3C);
        n = 0;
        while (!tx_rdy && n < LIM) begin @(negedge clk); n++; end
        thr(8'hC3);
        chk("R9 holding full not ready", int'(tx_rdy), 0);
        rx_char("R9 back to back first", 8'h3C);
        rx_char("R9 back to back second", 8'hC3);
        wait_cycles(2 * BITC);
        chk("R7 empty after drain", int'(tx_emt), 1);
    endtask

    task automatic t_break_idle;
        int n, lows;
        cmd(8'h60);
        wait_low(n);
        chk_le("R10 break start delay", n, 2 * BITC);
        count_lows(3 * BITC, lows);
        chk("R10 break held low", lows, 3 * BITC);
        cmd(8'h70);
        wait_high(n);
        chk_le("R13 break stop delay", n, 2 * BITC);
        thr(8'h5A);
        wait_low(n);
        chk_ge("R13 marking before next start", n + 2, BITC);
        begin
            int st, sp;
            logic [7:0] v;
            rx_after_start(v, st, sp);
            chk("R13 char after break", int'(v), 8'h5A);
        end
    endtask

    task automatic t_break_queued;
        int n;
        wait_cycles(2 * BITC);
        thr(8'h81);
        cmd(8'h60);
        n = 0;
        while (!tx_rdy && n < LIM) begin @(negedge clk); n++; end
        thr(8'h7E);
        rx_char("R11 first queued char", 8'h81);
        rx_char("R11 later loaded char", 8'h7E);
        wait_cycles(2 * BITC);
        chk("R11 break after queue", int'(txd), 0);
        cmd(8'h70);
        wait_cycles(3 * BITC);
        chk("R13 line released", int'(txd), 1);
    endtask

    task automatic t_break_disabled;
        int n, lows;
        cmd(8'h08);
        wait_cycles(2 * BITC);
        cmd(8'h60);
        count_lows(3 * BITC, lows);
        chk("R12 break ignored while disabled", lows, 0);
        cmd(8'h04);
        cmd(8'h68);
        count_lows(3 * BITC, lows);
        chk("R12 break ignored with disable in same write", lows, 0);
        cmd(8'h64);
        wait_low(n);
        chk_le("R12 break accepted with enable in same write", n, 2 * BITC);
        cmd(8'h70);
        wait_cycles(4 * BITC);
    endtask

    task automatic t_disable_drain;
        int lows;
        cmd(8'h04);
        thr(8'h96);
        cmd(8'h08);
        chk("R8 disable clears ready", int'(tx_rdy), 0);
        chk("R8 disable clears empty", int'(tx_emt), 0);
        rx_char("R8 held char drains", 8'h96);
        thr(8'h11);
        count_lows(3 * BITC, lows);
        chk("R8 load ignored while disabled", lows, 0);
    endtask

    task automatic t_tx_reset;
        int n, lows;
        cmd(8'h04);
        thr(8'hF0);
        wait_low(n);
        cmd(8'h30);
        chk("R4 reset forces line high", int'(txd), 1);
        chk("R4 reset disables", int'(tx_rdy), 0);
        count_lows(3 * BITC, lows);
        chk("R4 frame dropped", lows, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        wait_cycles(3);
        t_reset_state();
        rst_n = 1'b1;
        wait_cycles(2);
        t_reset_state();
        t_misc_strobes();
        t_rx_ctrl();
        t_frames();
        t_break_idle();
        t_break_queued();
        t_break_disabled();
        t_disable_drain();
        t_tx_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule